// File: doc/BRIEF.md
# Overlay Window Request Checker

This block vets a request to place an overlay window on top of a base display plane before the request reaches the overlay engine. A request carries a packed position and format word, the visible width and height of the window, the height of its virtual (scrollable) buffer, and the dimensions of the base plane. The block splits out the start row, start column and colour format, then checks that the format is known, that the start column and the line length fall on 32-bit word boundaries for the narrowest colour component of that format, and that the window fits inside the base plane.

A request that passes every rule is accepted, and the block reports the byte size of the buffer the window needs. It computes that size with a shift-and-add multiplier that takes one cycle per bit of the virtual height. A request that fails is rejected with a code naming the first rule it broke. The caller pulses `start_i` while `busy_o` is low, then waits for the one-cycle `done_o` pulse. The result stays on the outputs until the next request starts.

Top module: `ovl_win_check`

## Requirements
- R1: The request word `pos_fmt_i` holds the start row in bits 9:0, the start column in bits 19:10 and the colour format in bits 22:20.
- R2: Format codes are 0 RGB (16 bpp), 1 packed YUV 4:4:4 (24 bpp), 2 planar YUV 4:4:4 (24 bpp), 3 planar YUV 4:2:2 (16 bpp) and 4 planar YUV 4:2:0 (12 bpp). Codes 5 to 7 are rejected with error code 1.
- R3: The start column must be a multiple of the format's pixel alignment, or the request is rejected with error code 2. The alignment is 2 pixels for code 0, 4 for codes 1 and 2, 8 for code 3 and 16 for code 4.
- R4: The visible width must be a multiple of the same pixel alignment, or the request is rejected with error code 3.
- R5: If the start column plus the width exceeds the base width, or the start row plus the height exceeds the base height, the request is rejected with error code 4. A window that ends exactly on the base edge is accepted.
- R6: When several rules fail, the error code names the first failure in this order: format, column, line, bounds.
- R7: An accepted request reports `size_o` = width × virtual height × bpp / 8 bytes.
- R8: `busy_o` is high from the cycle after an accepted start until `done_o` rises. `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It does not change the result in progress and does not produce an extra `done_o`.
- R10: After reset, `busy_o`, `done_o` and `accept_o` are low.
- R11: With `done_o` high, `accept_o` = 1 comes with `err_o` = 0. `accept_o` = 0 comes with a nonzero `err_o` and `size_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a check (taken only when idle) |
| pos_fmt_i | input | 23 | Packed row, column and format word |
| width_i | input | 10 | Visible window width in pixels |
| height_i | input | 10 | Visible window height in lines |
| vheight_i | input | 12 | Virtual buffer height in lines |
| base_w_i | input | 10 | Base plane width |
| base_h_i | input | 10 | Base plane height |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle completion pulse |
| accept_o | output | 1 | Request accepted |
| err_o | output | 3 | Error code, 0 when accepted |
| size_o | output | 24 | Buffer size in bytes |

## Verification
The bench aims at the per-format alignment table and the priority order between rules. It uses a request that breaks both the column and the line rule in 4:2:0 mode, so a design with the priority swapped reports 3 instead of 2. It also uses an invalid format with a misaligned column, so a design that checks the format too late reports a column error. Windows that end exactly on the base edge catch an off-by-one bound, which would reject them. The 12-bpp and 24-bpp sizes, including the largest virtual height, catch a wrong scale factor or a truncated product. A start pulse sent mid-computation with a bad format would corrupt the pending result, or produce a second completion, in a design that did not lock out new starts.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_FMT    = 3'd1,
    ERR_COL    = 3'd2,
    ERR_LINE   = 3'd3,
    ERR_BOUNDS = 3'd4
  } err_e;

  // byte scale applied to width*vheight
  typedef enum logic [1:0] {
    SC_X2   = 2'd0,
    SC_X3   = 2'd1,
    SC_X1P5 = 2'd2
  } scale_e;
endpackage

// File: rtl/ovl_fmt_decode.sv
module ovl_fmt_decode
  import ovl_pkg::*;
(
  input  logic [2:0] fmt_i,
  output logic       fmt_ok_o,
  output logic [2:0] align_lg_o,
  output scale_e     scale_o
);
  always_comb begin
    fmt_ok_o   = 1'b1;
    align_lg_o = 3'd1;
    scale_o    = SC_X2;
    unique case (fmt_i)
      3'd0: begin align_lg_o = 3'd1; scale_o = SC_X2;   end
      3'd1: begin align_lg_o = 3'd2; scale_o = SC_X3;   end
      3'd2: begin align_lg_o = 3'd2; scale_o = SC_X3;   end
      3'd3: begin align_lg_o = 3'd3; scale_o = SC_X2;   end
      3'd4: begin align_lg_o = 3'd4; scale_o = SC_X1P5; end
      default: fmt_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ovl_rules.sv
module ovl_rules
  import ovl_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          fmt_ok_i,
  input  logic [2:0]    align_lg_i,
  input  logic [CW-1:0] col_i,
  input  logic [CW-1:0] row_i,
  input  logic [CW-1:0] width_i,
  input  logic [CW-1:0] height_i,
  input  logic [CW-1:0] base_w_i,
  input  logic [CW-1:0] base_h_i,
  output err_e          err_o
);
  logic [CW-1:0] mask;
  logic [CW:0]   x_end, y_end;
  logic          col_bad, line_bad, oob;

  assign mask     = (CW'(1) << align_lg_i) - CW'(1);
  assign col_bad  = (col_i & mask) != '0;
  assign line_bad = (width_i & mask) != '0;
  assign x_end    = {1'b0, col_i} + {1'b0, width_i};
  assign y_end    = {1'b0, row_i} + {1'b0, height_i};
  assign oob      = (x_end > {1'b0, base_w_i}) || (y_end > {1'b0, base_h_i});

  always_comb begin
    if (!fmt_ok_i)     err_o = ERR_FMT;
    else if (col_bad)  err_o = ERR_COL;
    else if (line_bad) err_o = ERR_LINE;
    else if (oob)      err_o = ERR_BOUNDS;
    else               err_o = ERR_NONE;
  end
endmodule

// File: rtl/ovl_shift_mul.sv
module ovl_shift_mul #(
  parameter int AW = 10,
  parameter int BW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   a_i,
  input  logic [BW-1:0]   b_i,
  output logic            done_o,
  output logic [AW+BW-1:0] prod_o
);
  localparam int PW  = AW + BW;
  localparam int CNW = $clog2(BW + 1);

  logic [PW-1:0]  acc_q, mcand_q;
  logic [BW-1:0]  mplier_q;
  logic [CNW-1:0] cnt_q;
  logic           run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        acc_q    <= '0;
        mcand_q  <= PW'(a_i);
        mplier_q <= b_i;
        cnt_q    <= CNW'(BW);
        run_q    <= 1'b1;
      end else if (run_q) begin
        if (mplier_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q - CNW'(1);
        if (cnt_q == CNW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = acc_q;

  p_mul_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q != '0);
  p_mul_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !run_q);
endmodule

// File: rtl/ovl_win_check.sv
module ovl_win_check
  import ovl_pkg::*;
#(
  parameter int CW  = 10,
  parameter int VHW = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [3*CW-8:0]     pos_fmt_i,
  input  logic [CW-1:0]       width_i,
  input  logic [CW-1:0]       height_i,
  input  logic [VHW-1:0]      vheight_i,
  input  logic [CW-1:0]       base_w_i,
  input  logic [CW-1:0]       base_h_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                accept_o,
  output logic [2:0]          err_o,
  output logic [CW+VHW+1:0]   size_o
);
  localparam int PW = CW + VHW;
  localparam int SW = PW + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_MUL} state_e;

  state_e        state_q;
  logic [CW-1:0] row_q, col_q, width_q, height_q, base_w_q, base_h_q;
  logic [2:0]    fmt_q;
  logic [VHW-1:0] vh_q;
  logic          done_q, accept_q;
  err_e          err_q;
  logic [SW-1:0] size_q;

  logic          fmt_ok;
  logic [2:0]    align_lg;
  scale_e        scale;
  err_e          rule_err;
  logic          mul_start, mul_done;
  logic [PW-1:0] prod;
  logic [SW-1:0] p2, p3, bytes;

  ovl_fmt_decode u_dec (
    .fmt_i     (fmt_q),
    .fmt_ok_o  (fmt_ok),
    .align_lg_o(align_lg),
    .scale_o   (scale)
  );

  ovl_rules #(.CW(CW)) u_rules (
    .fmt_ok_i  (fmt_ok),
    .align_lg_i(align_lg),
    .col_i     (col_q),
    .row_i     (row_q),
    .width_i   (width_q),
    .height_i  (height_q),
    .base_w_i  (base_w_q),
    .base_h_i  (base_h_q),
    .err_o     (rule_err)
  );

  assign mul_start = (state_q == ST_CHK) && (rule_err == ERR_NONE);

  ovl_shift_mul #(.AW(CW), .BW(VHW)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(mul_start),
    .a_i    (width_q),
    .b_i    (vh_q),
    .done_o (mul_done),
    .prod_o (prod)
  );

  // bytes = prod * bpp / 8
  assign p2 = {1'b0, prod, 1'b0};
  assign p3 = p2 + SW'(prod);
  always_comb begin
    unique case (scale)
      SC_X3:   bytes = p3;
      SC_X1P5: bytes = p3 >> 1;
      default: bytes = p2;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      fmt_q    <= '0;
      width_q  <= '0;
      height_q <= '0;
      vh_q     <= '0;
      base_w_q <= '0;
      base_h_q <= '0;
      done_q   <= 1'b0;
      accept_q <= 1'b0;
      err_q    <= ERR_NONE;
      size_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          row_q    <= pos_fmt_i[CW-1:0];
          col_q    <= pos_fmt_i[2*CW-1:CW];
          fmt_q    <= pos_fmt_i[2*CW+2:2*CW];
          width_q  <= width_i;
          height_q <= height_i;
          vh_q     <= vheight_i;
          base_w_q <= base_w_i;
          base_h_q <= base_h_i;
          state_q  <= ST_CHK;
        end
        ST_CHK: begin
          if (rule_err != ERR_NONE) begin
            done_q   <= 1'b1;
            accept_q <= 1'b0;
            err_q    <= rule_err;
            size_q   <= '0;
            state_q  <= ST_IDLE;
          end else begin
            state_q <= ST_MUL;
          end
        end
        ST_MUL: if (mul_done) begin
          done_q   <= 1'b1;
          accept_q <= 1'b1;
          err_q    <= ERR_NONE;
          size_q   <= bytes;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = done_q;
  assign accept_o = accept_q;
  assign err_o    = err_q;
  assign size_o   = size_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_accept_clean_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && accept_o) |-> err_o == 3'd0);
  p_reject_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !accept_o) |-> (err_o != 3'd0 && size_o == '0));
  p_bad_fmt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHK && fmt_q > 3'd4) |=> (done_o && err_o == 3'd1));
  p_hold_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(fmt_q) && $stable(width_q) && $stable(vh_q)));
endmodule

// File: tb/tb_ovl_win_check.sv
module tb_ovl_win_check;
  localparam int CW = 10;
  localparam int VHW = 12;
  localparam int SW = CW + VHW + 2;

  typedef struct packed {
    logic          acc;
    logic [2:0]    err;
    logic [SW-1:0] size;
    int unsigned   tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3*CW-8:0] pos_fmt = '0;
  logic [CW-1:0] width = '0, height = '0, base_w = '0, base_h = '0;
  logic [VHW-1:0] vheight = '0;
  logic busy, done, accept;
  logic [2:0] err;
  logic [SW-1:0] size;

  int checks = 0, errors = 0, results = 0, pushed = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  ovl_win_check #(.CW(CW), .VHW(VHW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pos_fmt_i(pos_fmt),
    .width_i(width), .height_i(height), .vheight_i(vheight),
    .base_w_i(base_w), .base_h_i(base_h), .busy_o(busy), .done_o(done),
    .accept_o(accept), .err_o(err), .size_o(size));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected result built from the requirement text
  function automatic exp_t model(input int fmt, input int col, input int row,
                                 input int w, input int h, input int vh,
                                 input int bw, input int bh, input int tag);
    exp_t e;
    int al, bpp;
    e.tag = tag; e.acc = 1'b0; e.size = '0;
    case (fmt)
      0: begin al = 2;  bpp = 16; end
      1, 2: begin al = 4; bpp = 24; end
      3: begin al = 8;  bpp = 16; end
      4: begin al = 16; bpp = 12; end
      default: begin al = 1; bpp = 0; end
    endcase
    if (fmt > 4) e.err = 3'd1;
    else if (col % al != 0) e.err = 3'd2;
    else if (w % al != 0) e.err = 3'd3;
    else if (col + w > bw || row + h > bh) e.err = 3'd4;
    else begin
      e.err = 3'd0; e.acc = 1'b1;
      e.size = SW'((longint'(w) * vh * bpp) / 8);
    end
    return e;
  endfunction

  task automatic run(input int fmt, input int col, input int row, input int w,
                     input int h, input int vh, input int bw, input int bh,
                     input int tag, input bit poke);
    @(negedge clk);
    while (busy) @(negedge clk);
    pos_fmt = {3'(fmt), CW'(col), CW'(row)};
    width = CW'(w); height = CW'(h); vheight = VHW'(vh);
    base_w = CW'(bw); base_h = CW'(bh);
    q.push_back(model(fmt, col, row, w, h, vh, bw, bh, tag));
    pushed++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    if (poke) begin
      // R9: bad request during busy must be ignored
      @(negedge clk);
      pos_fmt = {3'd7, 10'd3, 10'd0};
      width = 10'd7;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    chk(busy == 1'b0, "R8 idle after done", busy, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      results++;
      if (q.size() == 0) begin
        chk(1'b0, "R9 unexpected done", results, pushed);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(accept == e.acc, $sformatf("R5/R11 accept case %0d", e.tag), accept, e.acc);
        chk(err == e.err, $sformatf("R2/R3/R4/R5/R6 err case %0d", e.tag), err, e.err);
        chk(size == e.size, $sformatf("R7 size case %0d", e.tag), size, e.size);
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
      end
    end
  end

  initial begin
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy reset", busy, 0);
    chk(done == 1'b0, "R10 done reset", done, 0);
    chk(accept == 1'b0, "R10 accept reset", accept, 0);
    rst_n = 1'b1;
    run(0, 0, 0, 320, 240, 480, 640, 480, 1, 0);      // R1 R7 RGB
    run(5, 0, 0, 32, 8, 8, 640, 480, 2, 0);           // R2 bad fmt
    run(6, 3, 0, 33, 8, 8, 640, 480, 3, 0);           // R6 fmt before col
    run(0, 3, 0, 32, 8, 8, 640, 480, 4, 0);           // R3 RGB col
    run(4, 16, 0, 40, 8, 8, 640, 480, 5, 0);          // R4 420 line
    run(4, 4, 0, 40, 8, 8, 640, 480, 6, 0);           // R6 col before line
    run(0, 400, 0, 320, 8, 8, 640, 480, 7, 0);        // R5 x out
    run(0, 0, 300, 32, 200, 8, 640, 480, 8, 0);       // R5 y out
    run(0, 320, 240, 320, 240, 240, 640, 480, 9, 0);  // R5 exact fit
    run(4, 0, 0, 64, 64, 64, 640, 480, 10, 0);        // R7 12 bpp
    run(1, 4, 10, 100, 10, 20, 640, 480, 11, 0);      // R7 24 bpp packed
    run(3, 8, 0, 24, 8, 8, 640, 480, 12, 0);          // R7 422
    run(3, 4, 0, 24, 8, 8, 640, 480, 13, 0);          // R3 422 col
    run(2, 0, 0, 4, 1, 1, 640, 480, 14, 0);           // R7 planar 444
    run(1, 0, 0, 1000, 8, 4095, 1000, 480, 15, 0);    // R7 max vheight
    run(0, 2, 0, 64, 16, 32, 640, 480, 16, 1);        // R9 start ignored
    run(0, 0, 0, 100, 480, 480, 640, 479, 17, 0);     // R5 y one over
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R9 all results seen", q.size(), 0);
    chk(results == pushed, "R9 result count", results, pushed);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule